// File: doc/BRIEF.md
# Counter-Polled Centralized Bus Arbiter

This block decides which of N numbered agents may drive a shared bus. Every agent has its own request line. While the bus is free and a request is pending, a central counter walks through the agent numbers, one per clock. The counter value is broadcast to all agents. The agent whose number is on the count, and which is requesting, takes the bus. The arbiter then raises a single shared busy line, and the count stays frozen until that agent lets go.

Priority is set by where the count starts. A configuration register holds a programmable restart number and a restart-mode bit:

- **Fixed-order mode (mode bit 0):** each new polling round begins at the programmed number. Programming zero gives plain chain order, with agent 0 first.
- **Rotating mode (mode bit 1):** polling resumes at the agent after the last owner, so the order rotates.

Top module: `cpoll_arbiter`

## Requirements
- R1: After reset, `poll_vld_o`, `bus_busy_o` and every bit of `grant_o` are 0. `poll_cnt_o` is 0. The restart number is 0 and the restart-mode bit is 0.
- R2: While the bus is idle and no request is pending, `poll_vld_o` stays 0 and `poll_cnt_o` keeps its value.
- R3: When a request appears while idle, polling starts on the next clock with `poll_vld_o` = 1. In mode 0 the count is loaded with the restart number. In mode 1 the count keeps its held value.
- R4: In a poll cycle where the polled agent is not requesting and another agent is, the count advances by one on the next clock. The count wraps from N-1 to 0.
- R5: In a poll cycle where the polled agent is requesting, `bus_busy_o` is 1 on the next clock.
- R6: While `bus_busy_o` is 1 and the owner keeps its request, the count does not change.
- R7: When the owner drops its request, `bus_busy_o` is 0 on the next clock. On that same clock, `poll_vld_o` is 1 if any request is pending and 0 if none is.
- R8: In mode 0, a release sets the count to the restart number.
- R9: In mode 1, a release sets the count to the owner number plus one, wrapping N-1 to 0.
- R10: A cycle with `cfg_wr_i` = 1 loads `cfg_start_i` (which must be below N) and `cfg_cont_i` (0 selects mode 0, 1 selects mode 1). The new values govern state changes from the following clock on.
- R11: `grant_o` has at most one bit set. Bit i is set only while `bus_busy_o` is 1 and `poll_cnt_o` equals i.
- R12: In a poll cycle where no request is pending, polling stops on the next clock (`poll_vld_o` = 0) and the count is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | N_AGENTS | Request line per agent |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_start_i | input | CNT_W | Restart number to program |
| cfg_cont_i | input | 1 | Restart mode to program (1 = rotating) |
| poll_cnt_o | output | CNT_W | Broadcast poll count |
| poll_vld_o | output | 1 | Count is a live poll or owner number |
| bus_busy_o | output | 1 | Shared busy line |
| grant_o | output | N_AGENTS | Decoded owner, one-hot or zero |

## Verification
The bench builds the arbiter with N_AGENTS = 6, so the count width is 3 bits. With six agents, the wrap from 5 back to 0 is a deliberate step rather than a natural overflow of the counter. It also leaves counter codes 6 and 7 unused, which a broken wrap would land on. Directed sequences cover the walk to an owner, the frozen count while the bus is held, and both restart modes. A long random phase changes requests and configuration every few cycles, which reaches releases with and without pending requests.

// File: rtl/cpa_pkg.sv
package cpa_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_POLL = 2'd1,
    ST_HOLD = 2'd2
  } arb_state_e;

  typedef enum logic [1:0] {
    CNT_KEEP = 2'd0,
    CNT_STEP = 2'd1,
    CNT_LOAD = 2'd2
  } cnt_op_e;
endpackage

// File: rtl/cpa_cfg_reg.sv
module cpa_cfg_reg #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_start,
  input  logic             wr_cont,
  output logic [CNT_W-1:0] start_o,
  output logic             cont_o
);
  logic [CNT_W-1:0] start_q, start_d;
  logic             cont_q, cont_d;

  always_comb begin
    start_d = start_q;
    cont_d  = cont_q;
    if (wr_en) begin
      start_d = wr_start;
      cont_d  = wr_cont;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      cont_q  <= 1'b0;
    end else if (wr_en) begin
      start_q <= start_d;
      cont_q  <= cont_d;
    end
  end

  assign start_o = start_q;
  assign cont_o  = cont_q;
endmodule

// File: rtl/cpa_seq.sv
module cpa_seq
  import cpa_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       any_req,
  input  logic       hit,
  input  logic       cont_mode,
  output arb_state_e state_o,
  output cnt_op_e    op_o
);
  arb_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    op_o    = CNT_KEEP;
    unique case (state_q)
      ST_IDLE: begin
        if (any_req) begin
          state_d = ST_POLL;
          op_o    = cont_mode ? CNT_KEEP : CNT_LOAD;
        end
      end
      ST_POLL: begin
        if (hit) begin
          state_d = ST_HOLD;
        end else if (!any_req) begin
          state_d = ST_IDLE;
        end else begin
          op_o = CNT_STEP;
        end
      end
      ST_HOLD: begin
        if (!hit) begin
          state_d = any_req ? ST_POLL : ST_IDLE;
          op_o    = cont_mode ? CNT_STEP : CNT_LOAD;
        end
      end
      default: begin
        state_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/cpa_poll_ctr.sv
module cpa_poll_ctr
  import cpa_pkg::*;
#(
  parameter int N_AGENTS = 8,
  parameter int CNT_W    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cnt_op_e          op,
  input  logic [CNT_W-1:0] start,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(N_AGENTS - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    unique case (op)
      CNT_STEP: begin
        cnt_en = 1'b1;
        cnt_d  = (cnt_q == LAST) ? '0 : cnt_q + CNT_W'(1);
      end
      CNT_LOAD: begin
        cnt_en = 1'b1;
        cnt_d  = start;
      end
      default: begin
        cnt_en = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/cpa_match.sv
module cpa_match #(
  parameter int N_AGENTS = 8,
  parameter int CNT_W    = 3
) (
  input  logic [CNT_W-1:0]    cnt,
  input  logic [N_AGENTS-1:0] req,
  input  logic                busy,
  output logic                hit_o,
  output logic [N_AGENTS-1:0] grant_o
);
  logic [N_AGENTS-1:0] sel;

  for (genvar i = 0; i < N_AGENTS; i++) begin : g_cmp
    assign sel[i]     = (cnt == CNT_W'(i));
    assign grant_o[i] = busy & sel[i];
  end

  assign hit_o = |(req & sel);
endmodule

// File: rtl/cpoll_arbiter.sv
module cpoll_arbiter
  import cpa_pkg::*;
#(
  parameter int N_AGENTS = 8,
  parameter int CNT_W    = (N_AGENTS > 1) ? $clog2(N_AGENTS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_AGENTS-1:0] req_i,
  input  logic                cfg_wr_i,
  input  logic [CNT_W-1:0]    cfg_start_i,
  input  logic                cfg_cont_i,
  output logic [CNT_W-1:0]    poll_cnt_o,
  output logic                poll_vld_o,
  output logic                bus_busy_o,
  output logic [N_AGENTS-1:0] grant_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(N_AGENTS - 1);

  logic [CNT_W-1:0] start_w;
  logic             cont_w;
  logic             hit_w;
  logic             any_req;
  arb_state_e       state_w;
  cnt_op_e          op_w;
  logic [CNT_W-1:0] cnt_w;

  assign any_req = |req_i;

  cpa_cfg_reg #(.CNT_W(CNT_W)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (cfg_wr_i),
    .wr_start (cfg_start_i),
    .wr_cont  (cfg_cont_i),
    .start_o  (start_w),
    .cont_o   (cont_w)
  );

  cpa_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .any_req   (any_req),
    .hit       (hit_w),
    .cont_mode (cont_w),
    .state_o   (state_w),
    .op_o      (op_w)
  );

  cpa_poll_ctr #(.N_AGENTS(N_AGENTS), .CNT_W(CNT_W)) u_ctr (
    .clk   (clk),
    .rst_n (rst_n),
    .op    (op_w),
    .start (start_w),
    .cnt_o (cnt_w)
  );

  cpa_match #(.N_AGENTS(N_AGENTS), .CNT_W(CNT_W)) u_match (
    .cnt     (cnt_w),
    .req     (req_i),
    .busy    (bus_busy_o),
    .hit_o   (hit_w),
    .grant_o (grant_o)
  );

  assign poll_cnt_o = cnt_w;
  assign poll_vld_o = (state_w != ST_IDLE);
  assign bus_busy_o = (state_w == ST_HOLD);

  // Port-level checks
  assert_idle_stays_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!poll_vld_o && !any_req) |=> (!poll_vld_o && $stable(poll_cnt_o)));

  assert_step_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_vld_o && !bus_busy_o && any_req && !req_i[poll_cnt_o])
    |=> (poll_cnt_o == (($past(poll_cnt_o) == LAST) ? '0 : $past(poll_cnt_o) + CNT_W'(1))));

  assert_claim_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_vld_o && !bus_busy_o && req_i[poll_cnt_o]) |=> bus_busy_o);

  assert_freeze_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_busy_o && req_i[poll_cnt_o]) |=> (bus_busy_o && $stable(poll_cnt_o)));

  assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_busy_o && !req_i[poll_cnt_o]) |=> (!bus_busy_o && (poll_vld_o == $past(any_req))));

  assert_grant_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o));

  assert_stop_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_vld_o && !bus_busy_o && !any_req) |=> (!poll_vld_o && $stable(poll_cnt_o)));
endmodule

// File: tb/test_cpoll_arbiter.sv
module test_cpoll_arbiter;
  localparam int N   = 6;
  localparam int CW  = 3;
  localparam time TCLK = 10;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [N-1:0]  req;
  logic          cfg_wr;
  logic [CW-1:0] cfg_start;
  logic          cfg_cont;
  logic [CW-1:0] poll_cnt;
  logic          poll_vld;
  logic          bus_busy;
  logic [N-1:0]  grant;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference model state: 0 idle, 1 polling, 2 held
  int m_st, m_cnt, m_start, m_cont;

  always #(TCLK/2) clk = ~clk;

  cpoll_arbiter #(.N_AGENTS(N)) i_cpoll_arbiter (
    .clk(clk), .rst_n(rst_n), .req_i(req), .cfg_wr_i(cfg_wr),
    .cfg_start_i(cfg_start), .cfg_cont_i(cfg_cont),
    .poll_cnt_o(poll_cnt), .poll_vld_o(poll_vld),
    .bus_busy_o(bus_busy), .grant_o(grant)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step();
    int any = (req != 0);
    int hit = req[m_cnt];
    case (m_st)
      0: if (any) begin m_st = 1; if (!m_cont) m_cnt = m_start; end
      1: if (hit) m_st = 2;
         else if (!any) m_st = 0;
         else m_cnt = (m_cnt + 1) % N;
      default: if (!hit) begin
         m_cnt = m_cont ? (m_cnt + 1) % N : m_start;
         m_st  = any ? 1 : 0;
      end
    endcase
    if (cfg_wr) begin m_start = cfg_start; m_cont = cfg_cont; end
  endtask

  task automatic compare();
    int eg = (m_st == 2) ? (1 << m_cnt) : 0;
    chk(poll_vld == (m_st != 0), "R2 R12 poll_vld", poll_vld, m_st != 0);
    chk(bus_busy == (m_st == 2), "R5 R7 bus_busy", bus_busy, m_st == 2);
    chk(poll_cnt == m_cnt, "R4 R6 poll_cnt", poll_cnt, m_cnt);
    chk(grant == eg, "R11 grant", grant, eg);
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req = '0; cfg_wr = 0; cfg_start = '0; cfg_cont = 0;
    m_st = 0; m_cnt = 0; m_start = 0; m_cont = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(poll_vld == 0 && bus_busy == 0 && grant == 0 && poll_cnt == 0, "R1 reset outputs",
        {poll_vld, bus_busy, poll_cnt}, 0);
    rst_n = 1'b1;
    tick(); tick();
    chk(poll_vld == 0 && poll_cnt == 0, "R2 idle without request", poll_vld, 0);

    req = 6'b100000;
    tick();
    chk(poll_vld == 1 && poll_cnt == 0, "R3 polling starts at restart number", poll_cnt, 0);
    repeat (5) tick();
    chk(poll_cnt == 5 && !bus_busy, "R4 walk to agent 5", poll_cnt, 5);
    tick();
    chk(bus_busy == 1 && grant == 6'b100000, "R5 agent 5 owns bus", grant, 32);
    repeat (3) tick();
    chk(bus_busy == 1 && poll_cnt == 5, "R6 count frozen", poll_cnt, 5);

    req = 6'b000100;
    tick();
    chk(bus_busy == 0 && poll_vld == 1, "R7 release with pending request", bus_busy, 0);
    chk(poll_cnt == 0, "R8 mode 0 restart at 0", poll_cnt, 0);

    req = '0; cfg_wr = 1; cfg_start = 3'd4; cfg_cont = 0;
    tick();
    chk(poll_vld == 0, "R12 polling stops", poll_vld, 0);
    cfg_wr = 0; req = 6'b010000;
    tick();
    chk(poll_cnt == 4 && poll_vld == 1, "R10 new restart number used", poll_cnt, 4);
    tick();
    chk(bus_busy == 1 && poll_cnt == 4, "R5 agent 4 owns bus", poll_cnt, 4);
    cfg_wr = 1; cfg_cont = 1;
    tick();
    cfg_wr = 0; req = 6'b000010;
    tick();
    chk(bus_busy == 0 && poll_cnt == 5, "R9 rotate to owner plus one", poll_cnt, 5);
    tick();
    chk(poll_cnt == 0, "R4 wrap from 5 to 0", poll_cnt, 0);
    tick(); tick();
    chk(bus_busy == 1 && grant == 6'b000010, "R11 single grant to agent 1", grant, 2);

    for (int k = 0; k < 4000; k++) begin
      if ($urandom_range(0, 5) == 0) req = N'($urandom_range(0, (1 << N) - 1));
      if ($urandom_range(0, 9) == 0) req = '0;
      cfg_wr = ($urandom_range(0, 39) == 0);
      cfg_start = CW'($urandom_range(0, N - 1));
      cfg_cont = 1'($urandom_range(0, 1));
      tick();
    end
    cfg_wr = 0;

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule